// File: doc/BRIEF.md
# Interrupt presentation priority controller

This block sits beside one processor and decides which single interrupt, if any, is offered to it. It keeps a 32-bit status word: the upper priority field is the processor's current priority gate, and the lower field names the pending source. A source field of zero means nothing is pending. Source units deliver requests that carry a source number and a priority. A lower number means a more favoured priority. A request that cannot be taken, or a pending one that a better request pushes out, is handed back to its source through a reject strobe. The block also has a built-in inter-processor request register. A value written there is presented as a fixed source number whenever it beats the current gate.

Software drives the block through a command port with valid/ready signalling. The commands are: set current priority, set inter-processor priority, accept, poll and end-of-interrupt. Accept and poll return the status word one cycle later. End-of-interrupt forwards the completed source number to the sources. Whenever the unit becomes free to take new work, it pulses a resend request so that sources re-offer what they hold.

The core is a three-state machine over the kind of pending item. ST_EMPTY means nothing is pending. ST_SRC means a delivered source from a source unit is pending. ST_IPI means the inter-processor source is pending. The transitions are:
- EMPTY→SRC and IPI→SRC on a delivery that is taken.
- SRC→SRC on a displacing delivery.
- EMPTY/SRC/IPI→IPI when an inter-processor request is presented.
- SRC/IPI→EMPTY on accept, or on a current-priority drop that masks the pending item.

Top module: `intr_present_ctrl`

## Requirements
- R1: After reset the status word reads 0x00000000, the interrupt output is low, and both the pending priority and the inter-processor priority are 0xFF. No pulse output is active.
- R2: A delivery is refused in either of two cases: its priority is greater than or equal to the current priority, or something is pending with a priority less than or equal to the delivery's. A refused delivery gives a reject pulse carrying the delivered source number one cycle later, and the pending state does not change.
- R3: A delivery that is not refused becomes pending and raises the interrupt output. If it displaces a pending delivered source, that source is rejected in the same cycle. A displaced inter-processor source is never rejected.
- R4: Accept (opcode 3) returns the old status word on the response port one cycle later and lowers the output. The current priority takes the old pending priority, the source field becomes zero, and the pending priority becomes 0xFF.
- R5: Poll (opcode 4) returns the status word one cycle later and changes no state and no output.
- R6: Set current priority (opcode 1, value in data bits 7:0) can lower the gate. If the new value is below the old one and something is pending with a priority greater than or equal to the new value, the pending item is dropped. Dropping clears the source field, sets the pending priority to 0xFF, lowers the output, and rejects a dropped delivered source.
- R7: Set current priority with a value not below the old one, while nothing is pending, pulses resend. If the inter-processor priority is then below the new gate, the inter-processor source is presented at once.
- R8: Set inter-processor priority (opcode 2, value in data bits 7:0) stores the value. If the value is below the current priority and nothing pending has a priority less than or equal to it, source number 2 becomes pending with that priority and the output rises. A displaced delivered source is rejected in that case.
- R9: End-of-interrupt (opcode 5) sets the current priority from data bits 31:24 and pulses the end-of-interrupt output with data bits 23:0 one cycle later. If nothing is pending, it also performs the resend step of R7.
- R10: A command and a delivery offered in the same cycle are resolved in favour of the command: delivery ready is low and the delivery has no effect. Opcodes 0, 6 and 7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command taken (always high) |
| cmd_op | input | 3 | Command opcode |
| cmd_data | input | 32 | Command operand |
| rsp_valid | output | 1 | Status word returned by accept or poll |
| rsp_data | output | 32 | Returned status word |
| dlv_valid | input | 1 | Delivery offered by a source unit |
| dlv_ready | output | 1 | Delivery taken this cycle |
| dlv_src | input | 24 | Delivered source number |
| dlv_prio | input | 8 | Delivered priority |
| irq_out | output | 1 | Interrupt line to the processor |
| rej_valid | output | 1 | Reject pulse |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt pulse toward the sources |
| eoi_src | output | 24 | Completed source number |
| resend_pulse | output | 1 | Request to the sources to re-offer held work |

## Verification
The bench builds the block with its default parameters. These are a 24-bit source field, an 8-bit priority and source number 2 for the inter-processor request, which together give a 32-bit status word. With these values the bench can drive the 0xFF sentinel priority and the equal-priority boundaries of every comparison directly. It can also show the full status word, gate and source field together, on each poll. A scripted sequence walks the state machine through every transition, including the case where an inter-processor item is displaced without a reject and the case where a command overrides a simultaneous delivery.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_SRC   = 2'd1,
        ST_IPI   = 2'd2
    } pend_state_e;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_SET_CUR = 3'd1,
        OP_SET_IPR = 3'd2,
        OP_ACCEPT  = 3'd3,
        OP_POLL    = 3'd4,
        OP_EOI     = 3'd5
    } op_e;

    typedef struct packed {
        logic set_cur;
        logic set_ipr;
        logic accept;
        logic poll;
        logic eoi;
        logic dlv;
    } act_t;

endpackage

// File: rtl/ipc_cmd_dec.sv
module ipc_cmd_dec
    import ipc_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic       dlv_valid,
    output logic       cmd_ready,
    output logic       dlv_ready,
    output act_t       act
);

    assign cmd_ready = 1'b1;
    // a command always wins the cycle; deliveries wait
    assign dlv_ready = !cmd_valid;

    always_comb begin
        act     = '0;
        act.dlv = dlv_valid && !cmd_valid;
        if (cmd_valid) begin
            unique case (cmd_op)
                OP_SET_CUR: act.set_cur = 1'b1;
                OP_SET_IPR: act.set_ipr = 1'b1;
                OP_ACCEPT:  act.accept  = 1'b1;
                OP_POLL:    act.poll    = 1'b1;
                OP_EOI:     act.eoi     = 1'b1;
                default:    act.dlv     = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/ipc_pend_fsm.sv
module ipc_pend_fsm
    import ipc_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  act_t                      act,
    input  logic [PRIO_W+SRC_W-1:0]   cmd_data,
    input  logic [SRC_W-1:0]          dlv_src,
    input  logic [PRIO_W-1:0]         dlv_prio,
    output logic                      irq_out,
    output logic                      rsp_valid,
    output logic [PRIO_W+SRC_W-1:0]   rsp_data,
    output logic                      rej_valid,
    output logic [SRC_W-1:0]          rej_src,
    output logic                      eoi_valid,
    output logic [SRC_W-1:0]          eoi_src,
    output logic                      resend_pulse
);

    localparam int STAT_W = PRIO_W + SRC_W;
    localparam logic [PRIO_W-1:0] PRIO_OFF = {PRIO_W{1'b1}};
    localparam logic [SRC_W-1:0]  IPI_NUM  = SRC_W'(IPI_SRC);

    pend_state_e         state_q, state_d;
    logic [PRIO_W-1:0]   cur_q, cur_d, pend_q, pend_d, ipr_q, ipr_d;
    logic [SRC_W-1:0]    src_q, src_d;
    logic                irq_q, irq_d;
    logic                rej_d, eoi_d, rsd_d, rspv_d;
    logic [SRC_W-1:0]    rej_src_d, eoi_src_d;
    logic [STAT_W-1:0]   rsp_d;

    logic                pending, ipi_try;
    logic [PRIO_W-1:0]   new_prio, ipi_prio;

    assign pending  = (state_q != ST_EMPTY);
    assign new_prio = cmd_data[PRIO_W-1:0];
    assign ipi_prio = act.set_ipr ? new_prio : ipr_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_EMPTY;
            cur_q        <= '0;
            src_q        <= '0;
            pend_q       <= PRIO_OFF;
            ipr_q        <= PRIO_OFF;
            irq_q        <= 1'b0;
            rej_valid    <= 1'b0;
            rej_src      <= '0;
            eoi_valid    <= 1'b0;
            eoi_src      <= '0;
            resend_pulse <= 1'b0;
            rsp_valid    <= 1'b0;
            rsp_data     <= '0;
        end else begin
            state_q      <= state_d;
            cur_q        <= cur_d;
            src_q        <= src_d;
            pend_q       <= pend_d;
            ipr_q        <= ipr_d;
            irq_q        <= irq_d;
            rej_valid    <= rej_d;
            rej_src      <= rej_src_d;
            eoi_valid    <= eoi_d;
            eoi_src      <= eoi_src_d;
            resend_pulse <= rsd_d;
            rsp_valid    <= rspv_d;
            rsp_data     <= rsp_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        cur_d     = cur_q;
        src_d     = src_q;
        pend_d    = pend_q;
        ipr_d     = ipr_q;
        irq_d     = irq_q;
        rej_d     = 1'b0;
        rej_src_d = '0;
        eoi_d     = 1'b0;
        eoi_src_d = '0;
        rsd_d     = 1'b0;
        rspv_d    = 1'b0;
        rsp_d     = '0;
        ipi_try   = 1'b0;

        if (act.set_cur) begin
            cur_d = new_prio;
            if (new_prio < cur_q) begin
                if (pending && (new_prio <= pend_q)) begin
                    if (state_q == ST_SRC) begin
                        rej_d     = 1'b1;
                        rej_src_d = src_q;
                    end
                    state_d = ST_EMPTY;
                    src_d   = '0;
                    pend_d  = PRIO_OFF;
                    irq_d   = 1'b0;
                end
            end else if (!pending) begin
                rsd_d   = 1'b1;
                ipi_try = 1'b1;
            end
        end else if (act.set_ipr) begin
            ipr_d   = new_prio;
            ipi_try = 1'b1;
        end else if (act.accept || act.poll) begin
            rspv_d = 1'b1;
            rsp_d  = {cur_q, src_q};
            if (act.accept) begin
                state_d = ST_EMPTY;
                cur_d   = pend_q;
                src_d   = '0;
                pend_d  = PRIO_OFF;
                irq_d   = 1'b0;
            end
        end else if (act.eoi) begin
            cur_d     = cmd_data[STAT_W-1:SRC_W];
            eoi_d     = 1'b1;
            eoi_src_d = cmd_data[SRC_W-1:0];
            if (!pending) begin
                rsd_d   = 1'b1;
                ipi_try = 1'b1;
            end
        end else if (act.dlv) begin
            if ((dlv_prio >= cur_q) || (pending && (pend_q <= dlv_prio))) begin
                rej_d     = 1'b1;
                rej_src_d = dlv_src;
            end else begin
                if (state_q == ST_SRC) begin
                    rej_d     = 1'b1;
                    rej_src_d = src_q;
                end
                state_d = ST_SRC;
                src_d   = dlv_src;
                pend_d  = dlv_prio;
                irq_d   = 1'b1;
            end
        end

        if (ipi_try && (ipi_prio < cur_d) && !(pending && (pend_q <= ipi_prio))) begin
            unique case (state_q)
                ST_SRC: begin
                    rej_d     = 1'b1;
                    rej_src_d = src_q;
                end
                default: rej_d = rej_d;
            endcase
            state_d = ST_IPI;
            src_d   = IPI_NUM;
            pend_d  = ipi_prio;
            irq_d   = 1'b1;
        end
    end

    assign irq_out = irq_q;

    p_dlv_refused_r2: assert property (@(posedge clk) disable iff (!rst_n)
        act.dlv && (dlv_prio >= cur_q) |=> rej_valid && (rej_src == $past(dlv_src)) && $stable(src_q));

    p_line_follows_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (src_q != '0));

    p_accept_empties_r4: assert property (@(posedge clk) disable iff (!rst_n)
        act.accept |=> !irq_out && (src_q == '0) && (pend_q == PRIO_OFF) && (cur_q == $past(pend_q)));

    p_poll_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act.poll |=> rsp_valid && $stable(src_q) && $stable(cur_q) && $stable(irq_out));

    p_eoi_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
        act.eoi |=> eoi_valid && (eoi_src == $past(cmd_data[SRC_W-1:0]))
                    && (cur_q == $past(cmd_data[STAT_W-1:SRC_W])));

endmodule

// File: rtl/intr_present_ctrl.sv
module intr_present_ctrl
    import ipc_pkg::*;
#(
    parameter int SRC_W   = 24,
    parameter int PRIO_W  = 8,
    parameter int IPI_SRC = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    output logic                     cmd_ready,
    input  logic [2:0]               cmd_op,
    input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
    output logic                     rsp_valid,
    output logic [PRIO_W+SRC_W-1:0]  rsp_data,
    input  logic                     dlv_valid,
    output logic                     dlv_ready,
    input  logic [SRC_W-1:0]         dlv_src,
    input  logic [PRIO_W-1:0]        dlv_prio,
    output logic                     irq_out,
    output logic                     rej_valid,
    output logic [SRC_W-1:0]         rej_src,
    output logic                     eoi_valid,
    output logic [SRC_W-1:0]         eoi_src,
    output logic                     resend_pulse
);

    act_t act;

    ipc_cmd_dec u_dec (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .dlv_valid (dlv_valid),
        .cmd_ready (cmd_ready),
        .dlv_ready (dlv_ready),
        .act       (act)
    );

    ipc_pend_fsm #(
        .SRC_W   (SRC_W),
        .PRIO_W  (PRIO_W),
        .IPI_SRC (IPI_SRC)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .act          (act),
        .cmd_data     (cmd_data),
        .dlv_src      (dlv_src),
        .dlv_prio     (dlv_prio),
        .irq_out      (irq_out),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rej_valid    (rej_valid),
        .rej_src      (rej_src),
        .eoi_valid    (eoi_valid),
        .eoi_src      (eoi_src),
        .resend_pulse (resend_pulse)
    );

    p_cmd_beats_dlv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !dlv_ready);

endmodule

// File: tb/intr_present_ctrl_tb_top.sv
module intr_present_ctrl_tb_top;

    localparam logic [2:0] SETC = 3'd1, SETI = 3'd2, ACPT = 3'd3, POLL = 3'd4, EOI = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_ready;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic        dlv_valid = 1'b0, dlv_ready;
    logic [23:0] dlv_src = '0;
    logic [7:0]  dlv_prio = '0;
    logic        irq_out, rej_valid, eoi_valid, resend_pulse;
    logic [23:0] rej_src, eoi_src;

    always #10 clk = ~clk;

    intr_present_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
        .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
        .eoi_valid(eoi_valid), .eoi_src(eoi_src), .resend_pulse(resend_pulse)
    );

    typedef struct {
        int          cyc;
        string       tag;
        logic        rej;
        logic [23:0] rs;
        logic        eo;
        logic [23:0] es;
        logic        rsd;
        logic        rv;
        logic [31:0] rd;
        logic        irq;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // monitor: compare produced outputs against the queued expectation
    always @(negedge clk) begin
        exp_t e;
        if (q.size() > 0 && q[0].cyc == cyc) begin
            e = q.pop_front();
            check(e.tag, "rej_valid", 32'(rej_valid), 32'(e.rej));
            if (e.rej) check(e.tag, "rej_src", 32'(rej_src), 32'(e.rs));
            check(e.tag, "eoi_valid", 32'(eoi_valid), 32'(e.eo));
            if (e.eo) check(e.tag, "eoi_src", 32'(eoi_src), 32'(e.es));
            check(e.tag, "resend", 32'(resend_pulse), 32'(e.rsd));
            check(e.tag, "rsp_valid", 32'(rsp_valid), 32'(e.rv));
            if (e.rv) check(e.tag, "rsp_data", rsp_data, e.rd);
            check(e.tag, "irq_out", 32'(irq_out), 32'(e.irq));
        end
    end

    // driver: offer one cycle of stimulus and queue the expected result
    task automatic step(input logic cv, input logic [2:0] op, input logic [31:0] d,
                        input logic dv, input logic [23:0] ds, input logic [7:0] dp,
                        input string tag,
                        input logic rej, input logic [23:0] rs,
                        input logic eo, input logic [23:0] es,
                        input logic rsd, input logic rv, input logic [31:0] rd,
                        input logic irq);
        exp_t e;
        @(negedge clk);
        cmd_valid = cv; cmd_op = op; cmd_data = d;
        dlv_valid = dv; dlv_src = ds; dlv_prio = dp;
        e.cyc = cyc + 1; e.tag = tag;
        e.rej = rej; e.rs = rs; e.eo = eo; e.es = es;
        e.rsd = rsd; e.rv = rv; e.rd = rd; e.irq = irq;
        q.push_back(e);
        #1;
        if (cv && dv) check(tag, "dlv_ready", 32'(dlv_ready), 32'd0);
        @(posedge clk);
        #1;
        cmd_valid = 1'b0; dlv_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        step(0, 0, 0, 0, 0, 0, "R1 idle", 0, 0, 0, 0, 0, 0, 0, 0);
        step(1, POLL, 0, 0, 0, 0, "R1 poll", 0, 0, 0, 0, 0, 1, 32'h0000_0000, 0);
        // R2 refused against gate 0
        step(0, 0, 0, 1, 24'h10, 8'h05, "R2 gate", 1, 24'h10, 0, 0, 0, 0, 0, 0);
        // R7 open gate, nothing pending -> resend; ipr FF not below FF (R1)
        step(1, SETC, 32'hFF, 0, 0, 0, "R7 raise", 0, 0, 0, 0, 1, 0, 0, 0);
        // R3 take delivery
        step(0, 0, 0, 1, 24'h10, 8'h05, "R3 take", 0, 0, 0, 0, 0, 0, 0, 1);
        // R2 worse and equal priority against pending
        step(0, 0, 0, 1, 24'h20, 8'h07, "R2 worse", 1, 24'h20, 0, 0, 0, 0, 0, 1);
        step(0, 0, 0, 1, 24'h30, 8'h05, "R2 equal", 1, 24'h30, 0, 0, 0, 0, 0, 1);
        // R3 displacement
        step(0, 0, 0, 1, 24'h40, 8'h03, "R3 displace", 1, 24'h10, 0, 0, 0, 0, 0, 1);
        // R5 poll twice
        step(1, POLL, 0, 0, 0, 0, "R5 poll a", 0, 0, 0, 0, 0, 1, 32'hFF00_0040, 1);
        step(1, POLL, 0, 0, 0, 0, "R5 poll b", 0, 0, 0, 0, 0, 1, 32'hFF00_0040, 1);
        // R4 accept
        step(1, ACPT, 0, 0, 0, 0, "R4 accept", 0, 0, 0, 0, 0, 1, 32'hFF00_0040, 0);
        step(1, POLL, 0, 0, 0, 0, "R4 after", 0, 0, 0, 0, 0, 1, 32'h0300_0000, 0);
        // R9 eoi with nothing pending -> resend
        step(1, EOI, 32'hFF00_0040, 0, 0, 0, "R9 eoi empty", 0, 0, 1, 24'h40, 1, 0, 0, 0);
        step(0, 0, 0, 1, 24'h50, 8'h80, "R3 take2", 0, 0, 0, 0, 0, 0, 0, 1);
        // R6 gate drop masks pending source
        step(1, SETC, 32'h40, 0, 0, 0, "R6 drop", 1, 24'h50, 0, 0, 0, 0, 0, 0);
        step(1, POLL, 0, 0, 0, 0, "R6 after", 0, 0, 0, 0, 0, 1, 32'h4000_0000, 0);
        step(0, 0, 0, 1, 24'h60, 8'h10, "R3 take3", 0, 0, 0, 0, 0, 0, 0, 1);
        // R6 drop that keeps a better pending source
        step(1, SETC, 32'h20, 0, 0, 0, "R6 keep", 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, POLL, 0, 0, 0, 0, "R6 keep poll", 0, 0, 0, 0, 0, 1, 32'h2000_0060, 1);
        // R8 inter-processor request displaces delivered source
        step(1, SETI, 32'h08, 0, 0, 0, "R8 present", 1, 24'h60, 0, 0, 0, 0, 0, 1);
        step(1, POLL, 0, 0, 0, 0, "R8 poll", 0, 0, 0, 0, 0, 1, 32'h2000_0002, 1);
        step(1, SETI, 32'h05, 0, 0, 0, "R8 self", 0, 0, 0, 0, 0, 0, 0, 1);
        // R3/R8 delivery displaces the inter-processor source without reject
        step(0, 0, 0, 1, 24'h70, 8'h04, "R8 no reject", 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, SETI, 32'h06, 0, 0, 0, "R8 blocked", 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, POLL, 0, 0, 0, 0, "R8 blocked poll", 0, 0, 0, 0, 0, 1, 32'h2000_0070, 1);
        step(1, ACPT, 0, 0, 0, 0, "R4 accept2", 0, 0, 0, 0, 0, 1, 32'h2000_0070, 0);
        // R9 eoi with nothing pending presents the inter-processor source
        step(1, EOI, 32'h2000_0070, 0, 0, 0, "R9 eoi ipi", 0, 0, 1, 24'h70, 1, 0, 0, 1);
        step(1, POLL, 0, 0, 0, 0, "R9 poll", 0, 0, 0, 0, 0, 1, 32'h2000_0002, 1);
        // R9 eoi while pending: no resend
        step(1, EOI, 32'hFF00_0002, 0, 0, 0, "R9 eoi busy", 0, 0, 1, 24'h2, 0, 0, 0, 1);
        // R6 equal boundary drops inter-processor item with no reject
        step(1, SETC, 32'h06, 0, 0, 0, "R6 equal", 0, 0, 0, 0, 0, 0, 0, 0);
        // R7 raise presents inter-processor source
        step(1, SETC, 32'h10, 0, 0, 0, "R7 ipi", 0, 0, 0, 0, 1, 0, 0, 1);
        // R10 command beats delivery; undefined opcode ignored
        step(1, POLL, 0, 1, 24'h90, 8'h00, "R10 arb", 0, 0, 0, 0, 0, 1, 32'h1000_0002, 1);
        step(1, 3'd7, 32'h0000_00FF, 0, 0, 0, "R10 undef", 0, 0, 0, 0, 0, 0, 0, 1);
        step(1, POLL, 0, 0, 0, 0, "R10 after", 0, 0, 0, 0, 0, 1, 32'h1000_0002, 1);
        repeat (3) @(negedge clk);
        if (q.size() != 0) check("monitor", "queue", 32'(q.size()), 32'd0);
        finish_run();
    end

endmodule